// File: doc/BRIEF.md
# Program Counter Branch Unit

This block owns a 24-bit program counter and works out its next value for every change of control flow a simple processor core needs: plain advance, a short signed hop, jumps that rewrite only the low 11 or low 16 bits of the counter, a full 24-bit jump, three kinds of call, and two kinds of return. A decoder in front of it presents one operation at a time. Each operation carries an opcode, the length of the current instruction, and a 24-bit argument. The argument holds either a target address or, for the short hop, a signed byte.

Calls save the address of the next instruction through a byte-wide push stream. Returns collect it again through a byte-wide pop stream. The block keeps the stack pointer itself and drives the stack address on both streams, so the stack memory next to it only has to store and return bytes. Every stream uses valid/ready. A byte moves only on a clock edge where both sides are high. Back-pressure is absorbed by holding:
- `push_valid`, `push_addr` and `push_data` stay unchanged until `push_ready` is seen.
- `pop_ready` and `pop_addr` stay unchanged until `pop_valid` is seen.
- `pop_data` is taken at the edge where the pop handshake completes.

The operation input follows the same rule. `op_ready` is low while a stack transfer is in progress. A one-cycle `done` pulse marks the cycle after each operation finishes.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset `pc` is 0xFF0000, `sp` is 0x07, `op_ready` is 1, and `done`, `push_valid` and `pop_ready` are 0.
- R2: Opcode 0 (advance) and the reserved opcodes 10 to 15 set `pc` to `pc + op_len`, the next-instruction address, in the cycle after acceptance.
- R3: Opcode 1 (short hop) sets `pc` to next-instruction address plus `op_arg[7:0]` read as a signed value from -128 to +127. The sum wraps modulo 2^24.
- R4: Opcode 2 (block jump) and opcode 5 (block call) give a target whose bits 23:11 come from the next-instruction address and whose bits 10:0 come from `op_arg[10:0]`.
- R5: Opcode 3 (region jump) and opcode 6 (region call) give a target whose bits 23:16 come from the next-instruction address and whose bits 15:0 come from `op_arg[15:0]`.
- R6: Opcode 4 (far jump) and opcode 7 (far call) give `op_arg` as the whole 24-bit target.
- R7: Opcodes 5 and 6 push two bytes of the next-instruction address, bits 7:0 and then bits 15:8. Opcode 7 also pushes bits 23:16 as a third byte. Each byte is written to `sp + 1`, `sp` increments when its handshake completes, and `push_valid` and `pop_ready` are never high together.
- R8: Opcode 8 (near return) reads from address `sp` twice, decrementing `sp` after each byte. The first byte becomes `pc[15:8]`, the second becomes `pc[7:0]`, and `pc[23:16]` is kept. Opcode 9 (far return) reads three bytes in the same way, and they become bits 23:16, 15:8 and 7:0 in that order.
- R9: During a stack transfer, `pc` holds its old value until the handshake of the last byte. A stalled byte keeps its valid or ready signal, its address and its data unchanged.
- R10: `op_ready` is low from the acceptance of a call or return until it completes. An operation offered during that time is ignored.
- R11: `done` is high for exactly one cycle after each completed operation: the cycle after acceptance for jumps, and the cycle after the last byte handshake for calls and returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 4 | Operation opcode |
| op_len | input | 3 | Length of the current instruction in bytes |
| op_arg | input | 24 | Target address or signed offset in bits 7:0 |
| push_valid | output | 1 | Push byte available |
| push_ready | input | 1 | Stack accepts the push byte |
| push_addr | output | 8 | Stack address for the push byte |
| push_data | output | 8 | Byte to push |
| pop_ready | output | 1 | Unit requests a byte from the stack |
| pop_valid | input | 1 | Stack presents the popped byte |
| pop_addr | output | 8 | Stack address to read |
| pop_data | input | 8 | Popped byte |
| pc | output | 24 | Program counter |
| sp | output | 8 | Stack pointer |
| done | output | 1 | Operation completed, one-cycle pulse |

## Verification
Directed cases place the counter so that the next-instruction address crosses a 2-Kbyte boundary and the top of the 24-bit space. These cases separate a target built from the next address from one built from the current address, and they show whether the short hop and the advance wrap correctly. Both extreme offsets, +127 and -128, are exercised to confirm sign extension. Nested near and far calls followed by matching returns check the byte order on the stack and whether bits 23:16 are kept or restored. A long random sequence of mixed opcodes, lengths and arguments runs first with stacks that are always ready and then with random stalls on both streams, which separates correct holding under back-pressure from sequencing that advances too early. Operations offered while a transfer is in progress test R10.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;

  typedef enum logic [3:0] {
    OP_NEXT       = 4'd0,
    OP_HOP        = 4'd1,
    OP_BLOCK      = 4'd2,
    OP_REGION     = 4'd3,
    OP_FAR        = 4'd4,
    OP_CALL_BLOCK = 4'd5,
    OP_CALL_REGION= 4'd6,
    OP_CALL_FAR   = 4'd7,
    OP_RET_NEAR   = 4'd8,
    OP_RET_FAR    = 4'd9
  } pcbu_op_e;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [1:0] nbytes;
  } pcbu_xfer_t;

endpackage

// File: rtl/pcbu_target.sv
module pcbu_target
  import pcbu_pkg::*;
#(
  parameter int PC_W     = 24,
  parameter int LEN_W    = 3,
  parameter int BLOCK_W  = 11,
  parameter int REGION_W = 16
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [3:0]       code,
  input  logic [LEN_W-1:0] len,
  input  logic [PC_W-1:0]  arg,
  output logic [PC_W-1:0]  next_addr,
  output logic [PC_W-1:0]  target,
  output pcbu_xfer_t       xfer
);

  localparam int NEAR_BYTES = REGION_W / 8;
  localparam int FAR_BYTES  = (PC_W + 7) / 8;

  logic [PC_W-1:0] hop_t, block_t, region_t;

  always_comb begin
    next_addr = cur_pc + PC_W'(len);
    hop_t     = next_addr + {{(PC_W-8){arg[7]}}, arg[7:0]};
    block_t   = {next_addr[PC_W-1:BLOCK_W], arg[BLOCK_W-1:0]};
    region_t  = {next_addr[PC_W-1:REGION_W], arg[REGION_W-1:0]};
  end

  always_comb begin
    target = next_addr;
    xfer   = '0;
    case (pcbu_op_e'(code))
      OP_HOP:         target = hop_t;
      OP_BLOCK:       target = block_t;
      OP_REGION:      target = region_t;
      OP_FAR:         target = arg;
      OP_CALL_BLOCK: begin
        target = block_t;
        xfer   = '{push: 1'b1, pop: 1'b0, nbytes: 2'(NEAR_BYTES)};
      end
      OP_CALL_REGION: begin
        target = region_t;
        xfer   = '{push: 1'b1, pop: 1'b0, nbytes: 2'(NEAR_BYTES)};
      end
      OP_CALL_FAR: begin
        target = arg;
        xfer   = '{push: 1'b1, pop: 1'b0, nbytes: 2'(FAR_BYTES)};
      end
      OP_RET_NEAR:    xfer = '{push: 1'b0, pop: 1'b1, nbytes: 2'(NEAR_BYTES)};
      OP_RET_FAR:     xfer = '{push: 1'b0, pop: 1'b1, nbytes: 2'(FAR_BYTES)};
      default:        target = next_addr;
    endcase
  end

endmodule

// File: rtl/pcbu_stack_seq.sv
module pcbu_stack_seq
  import pcbu_pkg::*;
#(
  parameter int             PC_W     = 24,
  parameter int             SP_W     = 8,
  parameter int             KEEP_W   = 8,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pcbu_xfer_t        xfer,
  input  logic [PC_W-1:0]   push_word,
  input  logic [KEEP_W-1:0] keep_hi,
  output logic              busy,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [SP_W-1:0]   push_addr,
  output logic [7:0]        push_data,
  output logic              pop_ready,
  input  logic              pop_valid,
  output logic [SP_W-1:0]   pop_addr,
  input  logic [7:0]        pop_data,
  output logic [SP_W-1:0]   sp,
  output logic              finish,
  output logic              finish_pop,
  output logic [PC_W-1:0]   ret_addr
);

  localparam int LOW_W = PC_W - KEEP_W;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} seq_state_e;

  seq_state_e      state_q;
  logic [SP_W-1:0] sp_q;
  logic [1:0]      cnt_q, nbytes_q;
  logic            far_q;
  logic [PC_W-1:0] word_q;
  logic [PC_W-9:0] gather_q;
  logic [PC_W-1:0] gather_nxt;
  logic            push_hs, pop_hs, last;

  assign busy       = (state_q != S_IDLE);
  assign push_valid = (state_q == S_PUSH);
  assign pop_ready  = (state_q == S_POP);
  assign push_addr  = sp_q + SP_W'(1);
  assign pop_addr   = sp_q;
  assign push_data  = word_q[7:0];
  assign sp         = sp_q;
  assign push_hs    = push_valid && push_ready;
  assign pop_hs     = pop_ready && pop_valid;
  assign last       = (cnt_q == nbytes_q - 2'd1);
  assign gather_nxt = {gather_q, pop_data};
  assign finish     = (push_hs || pop_hs) && last;
  assign finish_pop = pop_hs && last;
  assign ret_addr   = far_q ? gather_nxt : {keep_hi, gather_nxt[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      sp_q     <= SP_RESET;
      cnt_q    <= '0;
      nbytes_q <= '0;
      far_q    <= 1'b0;
      word_q   <= '0;
      gather_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start && (xfer.push || xfer.pop)) begin
            state_q  <= xfer.push ? S_PUSH : S_POP;
            word_q   <= push_word;
            gather_q <= '0;
            cnt_q    <= '0;
            nbytes_q <= xfer.nbytes;
            far_q    <= (int'(xfer.nbytes) * 8 >= PC_W);
          end
        end
        S_PUSH: begin
          if (push_hs) begin
            sp_q   <= sp_q + SP_W'(1);
            word_q <= word_q >> 8;
            cnt_q  <= cnt_q + 2'd1;
            if (last) state_q <= S_IDLE;
          end
        end
        S_POP: begin
          if (pop_hs) begin
            sp_q     <= sp_q - SP_W'(1);
            gather_q <= gather_nxt[PC_W-9:0];
            cnt_q    <= cnt_q + 2'd1;
            if (last) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9: a stalled push keeps its offer unchanged
  assert_push_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data) && $stable(push_addr)));

  // R9: a stalled pop keeps its request unchanged
  assert_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ready && !pop_valid) |=> (pop_ready && $stable(pop_addr)));

  // R7: the two stack directions never overlap
  assert_one_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && pop_ready));

  // R7: each completed push advances the pointer by one
  assert_sp_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_hs |=> (sp == $past(sp) + SP_W'(1)));

  // R8: each completed pop lowers the pointer by one
  assert_sp_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_hs |=> (sp == $past(sp) - SP_W'(1)));

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcbu_pkg::*;
#(
  parameter int              PC_W     = 24,
  parameter int              SP_W     = 8,
  parameter int              LEN_W    = 3,
  parameter int              BLOCK_W  = 11,
  parameter int              REGION_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = 24'hFF0000,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [3:0]       op_code,
  input  logic [LEN_W-1:0] op_len,
  input  logic [PC_W-1:0]  op_arg,
  output logic             push_valid,
  input  logic             push_ready,
  output logic [SP_W-1:0]  push_addr,
  output logic [7:0]       push_data,
  output logic             pop_ready,
  input  logic             pop_valid,
  output logic [SP_W-1:0]  pop_addr,
  input  logic [7:0]       pop_data,
  output logic [PC_W-1:0]  pc,
  output logic [SP_W-1:0]  sp,
  output logic             done
);

  localparam int KEEP_W = PC_W - REGION_W;

  logic [PC_W-1:0] pc_q, tgt_q, next_addr, target, ret_addr;
  logic            done_q, busy, accept, finish, finish_pop;
  pcbu_xfer_t      xfer;

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;
  assign pc       = pc_q;
  assign done     = done_q;

  pcbu_target #(
    .PC_W(PC_W), .LEN_W(LEN_W), .BLOCK_W(BLOCK_W), .REGION_W(REGION_W)
  ) target_i (
    .cur_pc(pc_q), .code(op_code), .len(op_len), .arg(op_arg),
    .next_addr(next_addr), .target(target), .xfer(xfer)
  );

  pcbu_stack_seq #(
    .PC_W(PC_W), .SP_W(SP_W), .KEEP_W(KEEP_W), .SP_RESET(SP_RESET)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .xfer(xfer),
    .push_word(next_addr), .keep_hi(pc_q[PC_W-1:REGION_W]), .busy(busy),
    .push_valid(push_valid), .push_ready(push_ready), .push_addr(push_addr),
    .push_data(push_data), .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_addr(pop_addr), .pop_data(pop_data), .sp(sp), .finish(finish),
    .finish_pop(finish_pop), .ret_addr(ret_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      tgt_q  <= '0;
      done_q <= 1'b0;
    end else if (accept) begin
      if (xfer.push || xfer.pop) begin
        tgt_q  <= target;
        done_q <= 1'b0;
      end else begin
        pc_q   <= target;
        done_q <= 1'b1;
      end
    end else if (finish) begin
      pc_q   <= finish_pop ? ret_addr : tgt_q;
      done_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
    end
  end

  // R9: counter frozen while bytes are still moving
  assert_pc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(pc_q));

  // R10: completion is reported only once the sequencer is idle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> op_ready);

  // R11: a transfer that is not finishing produces no completion pulse
  assert_no_early_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> !done);

endmodule

// File: tb/pc_branch_unit_tb_top.sv
module pc_branch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_code = '0;
  logic [2:0]  op_len = 3'd1;
  logic [23:0] op_arg = '0;
  logic        push_valid, pop_ready;
  logic        push_ready = 1'b1;
  logic        pop_valid = 1'b1;
  logic [7:0]  push_addr, push_data, pop_addr, pop_data, sp;
  logic [23:0] pc;
  logic        done;

  logic [7:0]  mem [256];
  logic [7:0]  exp_mem [256];
  logic [23:0] e_pc = 24'hFF0000;
  logic [7:0]  e_sp = 8'h07;
  int          checks = 0, fails = 0;
  bit          stall_en = 1'b0;

  always #2 clk = ~clk;

  pc_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_len(op_len), .op_arg(op_arg),
    .push_valid(push_valid), .push_ready(push_ready), .push_addr(push_addr),
    .push_data(push_data), .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_addr(pop_addr), .pop_data(pop_data), .pc(pc), .sp(sp), .done(done)
  );

  assign pop_data = mem[pop_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (push_valid && push_ready) begin
      mem[push_addr] <= push_data;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (stall_en) begin
        push_ready = ($urandom % 3) != 0;
        pop_valid  = ($urandom % 3) != 0;
      end else begin
        push_ready = 1'b1;
        pop_valid  = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] f_target(input logic [3:0] code, input logic [23:0] cur,
                                           input logic [2:0] len, input logic [23:0] arg);
    logic [23:0] nxt;
    nxt = cur + 24'(len);
    case (code)
      4'd1:       return nxt + {{16{arg[7]}}, arg[7:0]};
      4'd2, 4'd5: return {nxt[23:11], arg[10:0]};
      4'd3, 4'd6: return {nxt[23:16], arg[15:0]};
      4'd4, 4'd7: return arg;
      default:    return nxt;
    endcase
  endfunction

  task automatic do_op(input logic [3:0] code, input logic [2:0] len,
                       input logic [23:0] arg, input bit inject);
    logic [23:0] nxt, old_pc, g;
    logic [7:0]  paddr [3];
    logic [7:0]  pbyte [3];
    int          npush, npop, n;
    old_pc = e_pc;
    nxt    = e_pc + 24'(len);
    npush  = (code == 4'd5 || code == 4'd6) ? 2 : (code == 4'd7) ? 3 : 0;
    npop   = (code == 4'd8) ? 2 : (code == 4'd9) ? 3 : 0;
    for (int k = 0; k < npush; k++) begin
      e_sp = e_sp + 8'd1;
      exp_mem[e_sp] = nxt[8*k +: 8];
      paddr[k] = e_sp;
      pbyte[k] = nxt[8*k +: 8];
    end
    g = '0;
    for (int k = 0; k < npop; k++) begin
      g = {g[15:0], exp_mem[e_sp]};
      e_sp = e_sp - 8'd1;
    end
    if (npop == 2)      e_pc = {e_pc[23:16], g[15:0]};
    else if (npop == 3) e_pc = g;
    else                e_pc = f_target(code, e_pc, len, arg);

    op_valid = 1'b1; op_code = code; op_len = len; op_arg = arg;
    @(negedge clk);
    op_valid = 1'b0;
    if (npush + npop > 0) chk("R10 op_ready low during transfer", 32'(op_ready), 32'd0);
    n = 0;
    while (!done && n < 64) begin
      chk("R9 pc held during transfer", 32'(pc), 32'(old_pc));
      if (inject) begin
        op_valid = 1'b1; op_code = 4'd4; op_arg = 24'h5A5A5A;
      end
      @(negedge clk);
      n++;
    end
    op_valid = 1'b0;
    chk("R11 done reported", 32'(done), 32'd1);
    if (npush > 0)      chk("R7 call target pc", 32'(pc), 32'(e_pc));
    else if (npop > 0)  chk("R8 return pc", 32'(pc), 32'(e_pc));
    else if (code == 4'd1) chk("R3 hop pc", 32'(pc), 32'(e_pc));
    else if (code == 4'd2) chk("R4 block pc", 32'(pc), 32'(e_pc));
    else if (code == 4'd3) chk("R5 region pc", 32'(pc), 32'(e_pc));
    else if (code == 4'd4) chk("R6 far pc", 32'(pc), 32'(e_pc));
    else                   chk("R2 advance pc", 32'(pc), 32'(e_pc));
    if (inject) chk("R10 offered op ignored", 32'(pc), 32'(e_pc));
    chk(npop > 0 ? "R8 sp after pops" : "R7 sp after pushes", 32'(sp), 32'(e_sp));
    for (int k = 0; k < npush; k++)
      chk("R7 pushed byte", 32'(mem[paddr[k]]), 32'(pbyte[k]));
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", 32'(pc), 32'hFF0000);
    chk("R1 reset sp", 32'(sp), 32'h07);
    chk("R1 reset op_ready", 32'(op_ready), 32'd1);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R1 reset push_valid", 32'(push_valid), 32'd0);
    chk("R1 reset pop_ready", 32'(pop_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(4'd0, 3'd3, 24'h0, 1'b0);          // R2 advance
    do_op(4'd4, 3'd4, 24'h0007FE, 1'b0);     // R6 far
    do_op(4'd2, 3'd3, 24'h123456, 1'b0);     // R4 next crosses 2K block
    do_op(4'd4, 3'd2, 24'hFFFFFE, 1'b0);
    do_op(4'd1, 3'd2, 24'h00007F, 1'b0);     // R3 +127 across top wrap
    do_op(4'd1, 3'd2, 24'h000080, 1'b0);     // R3 -128
    do_op(4'd4, 3'd1, 24'hFFFFFF, 1'b0);
    do_op(4'd0, 3'd1, 24'h0, 1'b0);          // R2 wrap to zero
    do_op(4'd4, 3'd3, 24'h12FFFD, 1'b0);
    do_op(4'd3, 3'd3, 24'hABCDEF, 1'b0);     // R5 next crosses 64K region
    do_op(4'd13, 3'd5, 24'hFFFFFF, 1'b0);    // R2 reserved opcode
    do_op(4'd6, 3'd3, 24'h004000, 1'b0);     // R7 region call
    do_op(4'd7, 3'd4, 24'h7A0010, 1'b1);     // R7 far call, R10 injection
    do_op(4'd5, 3'd2, 24'h000123, 1'b0);     // R7 block call
    do_op(4'd8, 3'd1, 24'h0, 1'b0);          // R8 near return
    do_op(4'd9, 3'd1, 24'h0, 1'b0);          // R8 far return
    do_op(4'd8, 3'd1, 24'h0, 1'b1);          // R8 near return keeps bits 23:16

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int i = 0; i < 300; i++) begin
        int c;
        c = $urandom % 12;
        do_op(4'(c), 3'(1 + $urandom % 5), 24'($urandom), ($urandom % 8) == 0);
      end
    end
    stall_en = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule